// File: doc/BRIEF.md
# Pin Interrupt Sense Controller

This block watches a small set of external interrupt pins and turns their activity into interrupt requests. Each pin has its own 2-bit sense code, which selects one of four trigger conditions: low level, any change, falling edge or rising edge. Every pin passes through a synchronizer, and the synchronized value is then sampled on the system clock. Edges are found by comparing the current sample with the one taken on the cycle before. Level requests follow the pin directly and are never stored. Edge and change detections set a per-pin flag, which stays set until software writes a one to it or an acknowledge pulse arrives.

Software reaches three registers over a simple synchronous write and combinational read port: the sense-code register, the mask register and the flag register. A request reaches its output only when the global enable input and the pin's mask bit are both high. A masked pin still records its edges, so the request appears as soon as the pin is unmasked. Comparison of samples carries on across changes of sense code. Rewriting a code while the pin is unmasked can therefore raise a request at once, so software should mask the pin before it changes the code.

Top module: `exti_sense_ctrl`

## Requirements
- R1: After reset the sense, mask and flag registers read zero and every request output is low.
- R2: Address 0 holds the sense codes, with pin i at bits [2i+1:2i], so pin 3 sits in bits [7:6] and pin 0 in bits [1:0]. Address 1 holds the mask, bit i for pin i. Address 2 holds the flags, bit i for pin i. Address 3 and the unused upper bits read zero. Written sense and mask values read back.
- R3: Code 00 (low level) raises the pin's request while the synchronized pin is low, two clock edges after the pin falls. The request drops when the pin goes high, and no flag is set.
- R4: Code 10 sets the pin's flag on a falling edge between two consecutive samples. The request stays high after the pin returns high.
- R5: Code 11 sets the flag on a rising edge only. A falling edge in this mode sets nothing, and pins with other codes are not affected.
- R6: Code 01 sets the flag on either edge.
- R7: An edge flag appears three clock edges after the pin changes, and a pulse two clock periods wide is caught.
- R8: A request output is high only when the global enable and the pin's mask bit are both high. Masked pins still set flags, and the request appears when the mask is set.
- R9: Writing 1 to a flag bit at address 2 clears that flag. Writing 0 leaves it unchanged.
- R10: A high acknowledge input clears that pin's flag. If a detection happens in the same cycle as a clear, the flag stays set.
- R11: Changing a sense code does not restart sampling. Switching a pin that is held low into code 00 raises its request on the cycle after the write.
- R12: Edge detection stays off until the synchronizer and the previous-sample register hold real pin values. A pin that is high through reset gives no flag, even when edge modes are selected right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 4 | External interrupt pins (asynchronous) |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 4 | Per-pin flag acknowledge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 4 | Per-pin interrupt requests |

## Verification
On every cycle, the assertions check four things: gating of each request by enable and mask, the level-mode request following the synchronized pin, that no flag rises in level mode or before sampling is armed, and that a clear with no coincident detection always empties the flag. Some behaviour can only be shown by the bench scenarios. These are the exact latency from pin to request, the capture of a two-cycle pulse, the bit positions of the sense codes, the priority of a detection over a simultaneous acknowledge, and the request that appears at once when the code changes while the pin is low.

// File: rtl/exti_pkg.sv
package exti_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam logic [1:0] ADDR_SENSE = 2'd0;
   localparam logic [1:0] ADDR_MASK  = 2'd1;
   localparam logic [1:0] ADDR_FLAG  = 2'd2;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("exti_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/exti_detect.sv
module exti_detect
   import exti_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   armed_i,
   input  logic   smp_i,
   input  sense_e mode_i,
   input  logic   clr_i,
   output logic   flag_o,
   output logic   level_o
);
   logic prev_q;
   logic flag_q;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= smp_i;
   end

   always_comb begin
      hit = 1'b0;
      if (armed_i) begin
         unique case (mode_i)
            SENSE_LOW:  hit = 1'b0;
            SENSE_ANY:  hit = smp_i ^ prev_q;
            SENSE_FALL: hit = prev_q & ~smp_i;
            SENSE_RISE: hit = smp_i & ~prev_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (hit)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o  = flag_q;
   assign level_o = (mode_i == SENSE_LOW) & ~smp_i;

   // R12
   no_early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_i |=> !$rose(flag_q));

   // R3
   level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SENSE_LOW) |=> !$rose(flag_q));

   // R9
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(armed_i && mode_i != SENSE_LOW && (smp_i != prev_q))) |=> !flag_q);
endmodule

// File: rtl/exti_regs.sv
module exti_regs
   import exti_pkg::*;
#(
   parameter int NUM_PINS = 4,
   parameter int DATA_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_i,
   input  logic [1:0]            addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  logic [NUM_PINS-1:0]   flag_i,
   output logic [DATA_W-1:0]     rdata_o,
   output logic [2*NUM_PINS-1:0] sense_o,
   output logic [NUM_PINS-1:0]   mask_o,
   output logic [NUM_PINS-1:0]   w1c_o
);
   localparam int SENSE_W = 2 * NUM_PINS;

   generate
      if (SENSE_W > DATA_W) begin : g_bad
         $error("exti_regs: DATA_W too narrow for sense codes");
      end
   endgenerate

   logic [SENSE_W-1:0]  sense_q;
   logic [NUM_PINS-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         mask_q  <= '0;
      end else if (wr_i) begin
         if (addr_i == ADDR_SENSE) sense_q <= wdata_i[SENSE_W-1:0];
         if (addr_i == ADDR_MASK)  mask_q  <= wdata_i[NUM_PINS-1:0];
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         ADDR_SENSE: rdata_o[SENSE_W-1:0]  = sense_q;
         ADDR_MASK:  rdata_o[NUM_PINS-1:0] = mask_q;
         ADDR_FLAG:  rdata_o[NUM_PINS-1:0] = flag_i;
         default:    rdata_o = '0;
      endcase
   end

   assign w1c_o   = (wr_i && addr_i == ADDR_FLAG) ? wdata_i[NUM_PINS-1:0] : '0;
   assign sense_o = sense_q;
   assign mask_o  = mask_q;

   // R2
   sense_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == ADDR_SENSE) |=> sense_q == $past(wdata_i[SENSE_W-1:0]));
endmodule

// File: rtl/exti_sense_ctrl.sv
module exti_sense_ctrl
   import exti_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic                gie_i,
   input  logic [NUM_PINS-1:0] ack_i,
   input  logic                reg_wr_i,
   input  logic [1:0]          reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   output logic [NUM_PINS-1:0] irq_o
);
   localparam int ARM_CNT = SYNC_STAGES + 1;
   localparam int ARM_W   = $clog2(ARM_CNT + 1);

   generate
      if (NUM_PINS < 1 || NUM_PINS > 8) begin : g_bad_pins
         $error("exti_sense_ctrl: NUM_PINS out of range");
      end
   endgenerate

   logic [ARM_W-1:0]      arm_cnt_q;
   logic                  armed;
   logic [2*NUM_PINS-1:0] sense;
   logic [NUM_PINS-1:0]   mask;
   logic [NUM_PINS-1:0]   w1c;
   logic [NUM_PINS-1:0]   flags;
   logic [NUM_PINS-1:0]   level;
   logic [NUM_PINS-1:0]   smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arm_cnt_q <= '0;
      else if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
   end
   assign armed = (arm_cnt_q == ARM_W'(ARM_CNT));

   exti_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .flag_i  (flags),
      .rdata_o (reg_rdata_o),
      .sense_o (sense),
      .mask_o  (mask),
      .w1c_o   (w1c)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      sense_e mode;
      assign mode = sense_e'(sense[2*i +: 2]);

      exti_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pins_i[i]),
         .q_o   (smp[i])
      );

      exti_detect u_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .armed_i (armed),
         .smp_i   (smp[i]),
         .mode_i  (mode),
         .clr_i   (w1c[i] | ack_i[i]),
         .flag_o  (flags[i]),
         .level_o (level[i])
      );

      assign irq_o[i] = gie_i & mask[i] & ((mode == SENSE_LOW) ? level[i] : flags[i]);

      // R8
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[i] |-> (gie_i && mask[i]));

      // R3
      level_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (gie_i && mask[i] && mode == SENSE_LOW && !smp[i]) |-> irq_o[i]);
   end
endmodule

// File: tb/exti_sense_ctrl_tb.sv
module exti_sense_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] pins;
   logic       gie;
   logic [3:0] ack;
   logic       wr;
   logic [1:0] addr;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic [3:0] irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   exti_sense_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .gie_i(gie), .ack_i(ack),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic cleanup();
      wreg(2'd0, 8'h00);
      wreg(2'd1, 8'h00);
      pins = 4'hF; ack = '0; gie = 1'b1;
      wait_n(4);
      wreg(2'd2, 8'h0F);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rreg(2'd0, d); chk("R1 sense reset", d, 8'h00);
      rreg(2'd1, d); chk("R1 mask reset", d, 8'h00);
      rreg(2'd2, d); chk("R1 flag reset", d, 8'h00);
      chk("R1 irq reset", irq, 4'h0);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wreg(2'd0, 8'hA5); rreg(2'd0, d); chk("R2 sense readback", d, 8'hA5);
      wreg(2'd1, 8'hFF); rreg(2'd1, d); chk("R2 mask width", d, 8'h0F);
      rreg(2'd3, d); chk("R2 addr3 zero", d, 8'h00);
      cleanup();
   endtask

   task automatic t_level();
      logic [7:0] d;
      wreg(2'd1, 8'h01);
      pins[0] = 1'b0;
      wait_n(1); chk("R3 level not yet", irq, 4'h0);
      wait_n(1); chk("R3 level asserted", irq, 4'h1);
      wait_n(3); chk("R3 level held", irq, 4'h1);
      pins[0] = 1'b1;
      wait_n(2); chk("R3 level drops", irq, 4'h0);
      rreg(2'd2, d); chk("R3 no flag", d, 8'h00);
      cleanup();
   endtask

   task automatic t_fall();
      logic [7:0] d;
      wreg(2'd0, 8'b0000_1000);
      wreg(2'd1, 8'h02);
      pins[1] = 1'b0;
      wait_n(3); chk("R4 fall request", irq, 4'h2);
      pins[1] = 1'b1;
      wait_n(4); chk("R4 latched", irq, 4'h2);
      wreg(2'd2, 8'h00);
      rreg(2'd2, d); chk("R9 write0 keeps", d, 8'h02);
      wreg(2'd2, 8'h02);
      rreg(2'd2, d); chk("R9 write1 clears", d, 8'h00);
      chk("R9 irq cleared", irq, 4'h0);
      cleanup();
   endtask

   task automatic t_rise();
      logic [7:0] d;
      wreg(2'd0, 8'hC0);
      wreg(2'd1, 8'h08);
      pins[3] = 1'b0;
      wait_n(4);
      rreg(2'd2, d); chk("R5 fall ignored", d, 8'h00);
      pins[3] = 1'b1;
      wait_n(4);
      rreg(2'd2, d); chk("R5 rise flag pin3 only", d, 8'h08);
      chk("R5 irq pin3", irq, 4'h8);
      cleanup();
   endtask

   task automatic t_any();
      logic [7:0] d;
      wreg(2'd0, 8'b0001_0000);
      pins[2] = 1'b0;
      wait_n(4);
      rreg(2'd2, d); chk("R6 fall flag", d, 8'h04);
      wreg(2'd2, 8'h04);
      pins[2] = 1'b1;
      wait_n(4);
      rreg(2'd2, d); chk("R6 rise flag", d, 8'h04);
      cleanup();
   endtask

   task automatic t_pulse();
      logic [7:0] d;
      pins[0] = 1'b0;
      wait_n(4);
      wreg(2'd0, 8'h03);
      wreg(2'd1, 8'h01);
      pins[0] = 1'b1;
      wait_n(2);
      pins[0] = 1'b0;
      chk("R7 no flag at 2 edges", irq, 4'h0);
      wait_n(1); chk("R7 flag at 3 edges", irq, 4'h1);
      wait_n(4);
      rreg(2'd2, d); chk("R7 pulse caught", d, 8'h01);
      cleanup();
   endtask

   task automatic t_gate();
      logic [7:0] d;
      wreg(2'd0, 8'b0010_0000);
      pins[2] = 1'b0;
      wait_n(4);
      rreg(2'd2, d); chk("R8 masked flag set", d, 8'h04);
      chk("R8 masked no irq", irq, 4'h0);
      wreg(2'd1, 8'h04);
      chk("R8 unmask irq", irq, 4'h4);
      gie = 1'b0;
      #1; chk("R8 gie off", irq, 4'h0);
      cleanup();
   endtask

   task automatic t_ack();
      logic [7:0] d;
      wreg(2'd0, 8'h01);
      wreg(2'd1, 8'h01);
      pins[0] = 1'b0;
      wait_n(4); chk("R10 flag before ack", irq, 4'h1);
      ack[0] = 1'b1;
      wait_n(1);
      ack[0] = 1'b0;
      rreg(2'd2, d); chk("R10 ack clears", d, 8'h00);
      pins[0] = 1'b1;
      wait_n(2);
      ack[0] = 1'b1;
      wait_n(1);
      ack[0] = 1'b0;
      rreg(2'd2, d); chk("R10 detect beats ack", d, 8'h01);
      cleanup();
   endtask

   task automatic t_modechg();
      logic [7:0] d;
      wreg(2'd0, 8'h03);
      wreg(2'd1, 8'h01);
      pins[0] = 1'b0;
      wait_n(4); chk("R11 rise mode quiet", irq, 4'h0);
      wreg(2'd0, 8'h00);
      chk("R11 switch to level fires", irq, 4'h1);
      pins[0] = 1'b1;
      wait_n(2); chk("R11 level releases", irq, 4'h0);
      rreg(2'd2, d); chk("R11 no flag", d, 8'h00);
      cleanup();
   endtask

   task automatic t_arm();
      logic [7:0] d;
      pins = 4'hF;
      rst_n = 1'b0;
      wait_n(2);
      rst_n = 1'b1;
      wreg(2'd0, 8'hFF);
      wait_n(6);
      rreg(2'd2, d); chk("R12 no false edge", d, 8'h00);
      cleanup();
   endtask

   initial begin
      rst_n = 1'b0; pins = 4'hF; gie = 1'b0; ack = '0;
      wr = 1'b0; addr = '0; wdata = '0;
      wait_n(3);
      rst_n = 1'b1;
      t_reset();
      gie = 1'b1;
      t_regs();
      t_level();
      t_fall();
      t_rise();
      t_any();
      t_pulse();
      t_gate();
      t_ack();
      t_modechg();
      t_arm();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule